// File: doc/BRIEF.md
# Slot Completion Bitmap with Programmable Slot Size

This block keeps track of which descriptor slots in a shared buffer have finished. Software programs a slot size, which splits the buffer into equal slots. A processing engine reports each finished descriptor with its byte offset in the buffer and a flag that says whether the far end acknowledged the transfer. The block divides the offset by the slot size to get a slot number. If the transfer was acknowledged, it sets the bit for that slot in a 32-bit completion bitmap.

The host reaches two registers through a small register port. One is the slot-size register, which can be read and written. The other is the completion bitmap, which can only be read, and which empties itself when the host reads it. A completion whose slot number would lie outside the bitmap, or that arrives while the slot size is zero, sets no bit and raises a one-cycle error pulse instead. A completion and a bitmap read may fall in the same cycle. In that case the read reports the old bitmap and the new bit is kept.

Top module: `slot_done_tracker`

## Requirements
- R1: After reset, the slot size reads 0, the bitmap reads 0 and `cpl_err` is low.
- R2: A write with `host_sel`=0 stores `host_wdata` with bits 15..10 and 2..0 forced to 0. Reading with `host_sel`=0 returns the stored size in bits 15..0, and all bits above 15 read 0.
- R3: A completion with `cpl_valid`=1 and `cpl_ack`=1 sets bitmap bit floor(`cpl_offset` / size), when the size is not zero and that slot number is below 32. The bit is visible from the next cycle.
- R4: A completion with `cpl_ack`=0 and a valid slot number sets no bit and raises no error.
- R5: A completion with `cpl_valid`=1 whose slot number is 32 or more, or that arrives while the size is 0, sets no bit. For such a completion, `cpl_err` is high for exactly the next cycle, whatever the value of `cpl_ack`.
- R6: `host_rdata` with `host_sel`=1 shows the bitmap in the same cycle. A cycle with `host_rd`=1 and `host_sel`=1 clears the bitmap at the end of that cycle.
- R7: If a clearing read and an acknowledged completion fall in the same cycle, the read shows the old bitmap, and afterwards the bitmap holds only the new bit.
- R8: A write with `host_sel`=1 leaves the bitmap unchanged.
- R9: A completion in the same cycle as a write to the slot size is decoded with the old size.
- R10: Set bits stay set until a clearing read. A second completion for a slot that is already set leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe; clears the bitmap when `host_sel`=1 |
| host_sel | input | 1 | Register select: 0 selects the slot size, 1 selects the bitmap |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 32 | Selected register, shown in the same cycle |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_ack | input | 1 | The completed transfer was acknowledged |
| cpl_offset | input | 16 | Byte offset of the completed descriptor |
| cpl_err | output | 1 | One-cycle pulse for a completion that cannot be mapped to a slot |

## Verification
The two events that can fall in the same cycle are a clearing bitmap read and an incoming completion; a slot-size write and a completion can also meet. The bench drives each pair deliberately in the same cycle. It then judges the outcome against a behavioural model in which the read value is taken before the clear and before the new bit is set, and the completion is decoded with the size that held before the edge. A random phase after the directed phases mixes all strobes, so that many more of these overlaps occur.

// File: rtl/slot_done_pkg.sv
package slot_done_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned SIZE_W  = 10;
  localparam int unsigned ALIGN_B = 3;
  localparam int unsigned SLOTS   = 32;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned IDX_W   = $clog2(SLOTS);

  typedef enum logic { SEL_SIZE = 1'b0, SEL_MAP = 1'b1 } reg_sel_e;
endpackage

// File: rtl/sdt_rst_sync.sv
module sdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdt_size_reg.sv
module sdt_size_reg #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned SIZE_W  = 10,
  parameter int unsigned ALIGN_B = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] size_q
);
  localparam logic [REG_W-1:0] KEEP_MASK =
    REG_W'(((1 << SIZE_W) - 1) & ~((1 << ALIGN_B) - 1));

  logic [REG_W-1:0] size_d;

  always_comb begin
    size_d = size_q;
    if (wr_en) size_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else        size_q <= size_d;
  end
endmodule

// File: rtl/sdt_slot_decode.sv
module sdt_slot_decode #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SLOTS = 32
) (
  input  logic [REG_W-1:0] slot_size,
  input  logic [OFF_W-1:0] offset,
  output logic             in_range,
  output logic [SLOTS-1:0] slot_vec
);
  localparam int unsigned IDX_W  = $clog2(SLOTS);
  localparam int unsigned PROD_W = REG_W + IDX_W + 1;
  localparam int unsigned CMP_W  = (OFF_W > PROD_W) ? OFF_W : PROD_W;

  logic [SLOTS-1:0] at_or_past;
  logic [IDX_W:0]   pass_cnt;
  logic [CMP_W-1:0] off_ext;

  assign off_ext = CMP_W'(offset);

  genvar k;
  generate
    for (k = 1; k <= SLOTS; k++) begin : g_bound
      logic [CMP_W-1:0] bound;
      assign bound = CMP_W'(slot_size) * CMP_W'(k);
      assign at_or_past[k-1] = (off_ext >= bound);
    end
  endgenerate

  always_comb begin
    pass_cnt = '0;
    for (int i = 0; i < SLOTS; i++) pass_cnt = pass_cnt + (IDX_W+1)'(at_or_past[i]);
  end

  always_comb begin
    in_range = (slot_size != '0) && !at_or_past[SLOTS-1];
    slot_vec = '0;
    if (in_range) slot_vec = SLOTS'(1) << pass_cnt[IDX_W-1:0];
  end
endmodule

// File: rtl/sdt_done_map.sv
module sdt_done_map #(
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [SLOTS-1:0] set_vec,
  input  logic             clr,
  output logic [SLOTS-1:0] map_q
);
  logic [SLOTS-1:0] base;
  logic [SLOTS-1:0] map_d;

  always_comb begin
    base  = clr ? '0 : map_q;
    map_d = set_en ? (base | set_vec) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end
endmodule

// File: rtl/slot_done_tracker.sv
module slot_done_tracker
  import slot_done_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [SLOTS-1:0] host_rdata,
  input  logic             cpl_valid,
  input  logic             cpl_ack,
  input  logic [OFF_W-1:0] cpl_offset,
  output logic             cpl_err
);
  logic             rst_sync_n;
  logic [REG_W-1:0] size_q;
  logic             slot_ok;
  logic [SLOTS-1:0] slot_vec;
  logic [SLOTS-1:0] done_map;
  logic             size_wr_en;
  logic             map_clr;
  logic             map_set_en;
  logic             err_d;
  logic             err_q;

  sdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign size_wr_en = host_wr && (reg_sel_e'(host_sel) == SEL_SIZE);
  assign map_clr    = host_rd && (reg_sel_e'(host_sel) == SEL_MAP);
  assign map_set_en = cpl_valid && cpl_ack && slot_ok;

  sdt_size_reg #(.REG_W(REG_W), .SIZE_W(SIZE_W), .ALIGN_B(ALIGN_B)) u_size (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(size_wr_en),
    .wr_data(host_wdata), .size_q(size_q)
  );

  sdt_slot_decode #(.REG_W(REG_W), .OFF_W(OFF_W), .SLOTS(SLOTS)) u_dec (
    .slot_size(size_q), .offset(cpl_offset),
    .in_range(slot_ok), .slot_vec(slot_vec)
  );

  sdt_done_map #(.SLOTS(SLOTS)) u_map (
    .clk(clk), .rst_n(rst_sync_n), .set_en(map_set_en),
    .set_vec(slot_vec), .clr(map_clr), .map_q(done_map)
  );

  always_comb err_d = cpl_valid && !slot_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign cpl_err = err_q;

  always_comb begin
    if (reg_sel_e'(host_sel) == SEL_MAP) host_rdata = done_map;
    else                                 host_rdata = SLOTS'(size_q);
  end
endmodule

// File: rtl/slot_done_tracker_chk.sv
module slot_done_tracker_chk #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_rd,
  input logic             host_sel,
  input logic             cpl_valid,
  input logic             cpl_ack,
  input logic             cpl_err,
  input logic [REG_W-1:0] size_q,
  input logic [SLOTS-1:0] map_q
);
  AST_SIZE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    size_q[2:0] == 3'b000 && size_q[REG_W-1:10] == '0); // R2

  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_sel) |=> ((map_q & $past(map_q)) == $past(map_q))); // R10

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && !(cpl_valid && cpl_ack)) |=> (map_q == '0)); // R6

  AST_ONE_BIT_PER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_sel) |=> ($countones(map_q ^ $past(map_q)) <= 1)); // R3

  AST_NAK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpl_valid && cpl_ack) && !(host_rd && host_sel)) |=> $stable(map_q)); // R4

  AST_ERR_NEEDS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> !cpl_err); // R5
endmodule

bind slot_done_tracker slot_done_tracker_chk #(.SLOTS(slot_done_pkg::SLOTS), .REG_W(slot_done_pkg::REG_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_rd(host_rd), .host_sel(host_sel),
  .cpl_valid(cpl_valid), .cpl_ack(cpl_ack), .cpl_err(cpl_err),
  .size_q(size_q), .map_q(done_map)
);

// File: tb/slot_done_tracker_bench.sv
module slot_done_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cpl_valid = 1'b0, cpl_ack = 1'b0;
  logic [15:0] cpl_offset = '0;
  logic        cpl_err;

  int          n_cmp = 0, n_bad = 0;
  string       tag = "R1";
  bit          run_done = 1'b0;

  int          m_size = 0;
  bit [31:0]   m_map = '0;
  bit          m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_done_tracker u_slot_done_tracker (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpl_valid(cpl_valid), .cpl_ack(cpl_ack), .cpl_offset(cpl_offset),
    .cpl_err(cpl_err)
  );

  task automatic compare_now();
    bit [31:0] exp_rd;
    exp_rd = host_sel ? m_map : 32'(m_size);
    n_cmp++;
    if (host_rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata actual %h expected %h", tag, host_rdata, exp_rd);
    end
    n_cmp++;
    if (cpl_err !== m_err) begin
      n_bad++;
      $display("FAIL %s cpl_err actual %b expected %b", tag, cpl_err, m_err);
    end
  endtask

  // one clock: inputs are already driven; compare, then advance model at edge
  task automatic tick();
    int        nsize;
    bit [31:0] nmap;
    bit        nerr;
    int        idx;
    #1;
    compare_now();
    nsize = m_size;
    nmap  = (host_rd && host_sel) ? 32'h0 : m_map;
    nerr  = 1'b0;
    if (host_wr && !host_sel) nsize = int'(host_wdata) & 16'h03F8;
    if (cpl_valid) begin
      if (m_size == 0) nerr = 1'b1;
      else begin
        idx = int'(cpl_offset) / m_size;
        if (idx >= 32) nerr = 1'b1;
        else if (cpl_ack) nmap[idx] = 1'b1;
      end
    end
    @(posedge clk);
    m_size = nsize; m_map = nmap; m_err = nerr;
    @(negedge clk);
    host_wr = 0; host_rd = 0; cpl_valid = 0; cpl_ack = 0;
  endtask

  task automatic idle_look(input bit sel);
    host_sel = sel; tick();
  endtask

  task automatic wr_size(input logic [15:0] v);
    host_wr = 1; host_sel = 0; host_wdata = v; tick();
    idle_look(0);
  endtask

  task automatic cpl(input int off, input bit ack);
    cpl_valid = 1; cpl_ack = ack; cpl_offset = 16'(off); host_sel = 1; tick();
    idle_look(1);
  endtask

  task automatic rd_map();
    host_rd = 1; host_sel = 1; tick();
    idle_look(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!run_done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1"; idle_look(0); idle_look(1);

    tag = "R2";
    wr_size(16'hFFFF); wr_size(16'h0047); wr_size(16'h0010);

    tag = "R3";
    cpl(0, 1); cpl(17, 1); cpl(16*31 + 15, 1); cpl(16*5, 1);
    wr_size(16'h0028); cpl(40*7 - 1, 1); cpl(40*7, 1);

    tag = "R4";
    cpl(40*12, 0);

    tag = "R5";
    cpl(40*32, 1); cpl(40*32 + 3, 0); cpl(16'hFFFF, 1);
    wr_size(16'h0003); cpl(0, 1); cpl(5, 0);

    tag = "R6";
    wr_size(16'h0008); cpl(8*9, 1); rd_map(); rd_map();

    tag = "R7";
    cpl(8*3, 1);
    host_rd = 1; host_sel = 1; cpl_valid = 1; cpl_ack = 1; cpl_offset = 16'(8*20); tick();
    idle_look(1);

    tag = "R8";
    host_wr = 1; host_sel = 1; host_wdata = 16'hFFFF; tick();
    idle_look(1); idle_look(0);

    tag = "R9";
    host_wr = 1; host_sel = 0; host_wdata = 16'h0100;
    cpl_valid = 1; cpl_ack = 1; cpl_offset = 16'(8*30); tick();
    idle_look(1); idle_look(0);

    tag = "R10";
    cpl(0, 1); cpl(5, 1); cpl(256*4, 1); cpl(256*4 + 1, 1);
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) begin host_wr = 1; host_wdata = 16'($urandom); end
      host_sel   = 1'($urandom);
      host_rd    = (($urandom % 8) == 0);
      cpl_valid  = 1'($urandom);
      cpl_ack    = (($urandom % 4) != 0);
      cpl_offset = 16'($urandom % 12000);
      tick();
    end

    run_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule